// File: doc/BRIEF.md
# Four-Lane DDR Sample Serializer

This block sits at the digital output edge of a four-channel converter. Each sample period it receives one 12-bit result per channel and turns each into a serial stream on its own lane. Every lane carries two bits per bit-clock period, one while the bit clock is high and one while it is low, so a full word fits in one sample period. All four lanes share one bit-clock enable and one frame clock, and their most significant bits start in the same cycle.

The whole block runs on the fast clock, which has the bit-clock frequency (six times the sample rate at the default width). The sample clock domain is represented by a one-cycle `smp_valid` strobe that is synchronous to the fast clock. Each word goes first into a holding register. It moves into the shift registers only at a frame boundary, so a frame in progress is never disturbed. A lock input freezes the outputs while the clock source is not ready. A power-down input silences the outputs and ignores new samples.

Top module: `quad_ddr_serializer`

## Requirements
- R1: After reset, `lane_hi`, `lane_lo`, `frame_clk` and `bclk_en` are all 0.
- R2: Each lane sends its channel's 12-bit word MSB first over 6 fast-clock cycles. In the k-th cycle of a frame (k = 0..5), `lane_hi[c]` carries bit 11-2k and `lane_lo[c]` carries bit 10-2k of channel c's word. Channel c's word is `smp_data[12c+11:12c]`.
- R3: All lanes start their MSB in the same cycle, and a frame lasts exactly 6 cycles. `bclk_en` is 1 while frames are being sent.
- R4: `frame_clk` is 1 in cycles 0..2 of each frame and 0 in cycles 3..5, so it rises together with the MSB.
- R5: A word presented with `smp_valid` is held and loaded only at the next frame start. A later strobe before that start replaces it, and a frame in progress is never altered. With no new strobe, the held word is sent again.
- R6: While `pll_lock` is 0 (and `pwr_down` is 0), the lanes and `frame_clk` keep their values and `bclk_en` is 0. Once lock returns, a new frame starts at once with the held word.
- R7: The cycle after `pwr_down` is 1, all lanes, `frame_clk` and `bclk_en` are 0. Strobes during power-down are ignored: after release, the word held before power-down is sent.
- R8: Words are sent bit-exact with no recoding. Offset-binary codes 0x000, 0x7FF, 0x800 and 0xFFF appear on the lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock at the bit-clock rate |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | One-cycle strobe marking a new set of samples |
| smp_data | input | 48 | Four 12-bit samples, channel c at bits 12c+11..12c |
| pll_lock | input | 1 | Clock source locked; 0 freezes the outputs |
| pwr_down | input | 1 | Active-high power-down |
| lane_hi | output | 4 | Per-lane bit sent while the bit clock is high |
| lane_lo | output | 4 | Per-lane bit sent while the bit clock is low |
| bclk_en | output | 1 | Bit clock running |
| frame_clk | output | 1 | Frame clock, high for the first half of each word |

## Verification
The bench builds the block with its default four channels and 12-bit words, so a frame is six fast cycles and the half-frame split falls on an odd cycle count. With these values the bench can cover several cases: distinct per-channel words that expose lane swaps, the extreme offset-binary codes, strobes landing in every phase of a frame, and lock loss and power-down arriving mid-frame. A behavioural model indexes bit positions in the held words and is compared with every output on every cycle.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_RUN  = 2'd2
  } ser_mode_e;
endpackage

// File: rtl/ser_hold.sv
module ser_hold #(
  parameter int NCH   = 4,
  parameter int WBITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic                 pdwn,
  input  logic [NCH*WBITS-1:0] din,
  output logic [NCH*WBITS-1:0] hold
);
  logic                 cap_en;
  logic [NCH*WBITS-1:0] hold_n;

  always_comb begin
    cap_en = valid & ~pdwn;
    hold_n = cap_en ? din : hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else        hold <= hold_n;
  end

  // R5 / R7: without an accepted strobe the holding register keeps its word
  p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && !pdwn) |=> $stable(hold));
endmodule

// File: rtl/ser_frame_ctl.sv
module ser_frame_ctl
  import ser_pkg::*;
#(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic pdwn,
  output logic load,
  output logic shift,
  output logic clr,
  output logic frm,
  output logic run
);
  localparam int PW   = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int HALF = CYC / 2;

  ser_mode_e       mode, mode_n;
  logic [PW-1:0]   ph, ph_n;
  logic            frm_n;

  always_comb begin
    mode_n = mode;
    ph_n   = ph;
    frm_n  = frm;
    load   = 1'b0;
    shift  = 1'b0;
    clr    = 1'b0;
    if (pdwn) begin
      mode_n = MODE_OFF;
      ph_n   = '0;
      frm_n  = 1'b0;
      clr    = 1'b1;
    end else if (!lock) begin
      mode_n = MODE_WAIT;
    end else if (mode != MODE_RUN || ph == PW'(CYC - 1)) begin
      mode_n = MODE_RUN;
      ph_n   = '0;
      frm_n  = 1'b1;
      load   = 1'b1;
    end else begin
      ph_n   = ph + 1'b1;
      frm_n  = (int'(ph) + 1) < HALF;
      shift  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_WAIT;
      ph   <= '0;
      frm  <= 1'b0;
    end else begin
      mode <= mode_n;
      ph   <= ph_n;
      frm  <= frm_n;
    end
  end

  assign run = (mode == MODE_RUN);

  // R3: the phase never leaves the frame
  p_ph_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) < CYC);
  // R4: frame clock rises only on the first cycle of a frame
  p_frm_rise_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm) |-> (ph == '0 && run));
  // R6: while unlocked the frame clock and phase are frozen
  p_unlock_static_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && !pdwn) |=> ($stable(frm) && $stable(ph)));
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int WBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             clr,
  input  logic [WBITS-1:0] word,
  output logic             bit_hi,
  output logic             bit_lo
);
  logic [WBITS-1:0] sh, sh_n;

  always_comb begin
    sh_n = sh;
    if (clr)        sh_n = '0;
    else if (load)  sh_n = word;
    else if (shift) sh_n = {sh[WBITS-3:0], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_n;
  end

  assign bit_hi = sh[WBITS-1];
  assign bit_lo = sh[WBITS-2];
endmodule

// File: rtl/quad_ddr_serializer.sv
module quad_ddr_serializer #(
  parameter int NCH   = 4,
  parameter int WBITS = 12
) (
  input  logic                 clk_fast,
  input  logic                 arst_n,
  input  logic                 smp_valid,
  input  logic [NCH*WBITS-1:0] smp_data,
  input  logic                 pll_lock,
  input  logic                 pwr_down,
  output logic [NCH-1:0]       lane_hi,
  output logic [NCH-1:0]       lane_lo,
  output logic                 bclk_en,
  output logic                 frame_clk
);
  localparam int CYC = WBITS / 2;

  logic [1:0]           rst_sync;
  logic                 rst_n;
  logic [NCH*WBITS-1:0] hold;
  logic                 load, shift, clr;

  always_ff @(posedge clk_fast or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  ser_hold #(.NCH(NCH), .WBITS(WBITS)) u_hold (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .valid (smp_valid),
    .pdwn  (pwr_down),
    .din   (smp_data),
    .hold  (hold)
  );

  ser_frame_ctl #(.CYC(CYC)) u_ctl (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .lock  (pll_lock),
    .pdwn  (pwr_down),
    .load  (load),
    .shift (shift),
    .clr   (clr),
    .frm   (frame_clk),
    .run   (bclk_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    ser_lane #(.WBITS(WBITS)) u_lane (
      .clk    (clk_fast),
      .rst_n  (rst_n),
      .load   (load),
      .shift  (shift),
      .clr    (clr),
      .word   (hold[c*WBITS +: WBITS]),
      .bit_hi (lane_hi[c]),
      .bit_lo (lane_lo[c])
    );
  end

  // R7: power-down silences every output on the following cycle
  p_pdwn_quiet_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    pwr_down |=> (lane_hi == '0 && lane_lo == '0 && !frame_clk && !bclk_en));
  // R6: loss of lock freezes the data lanes
  p_unlock_lanes_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!pll_lock && !pwr_down) |=> ($stable(lane_hi) && $stable(lane_lo) && !bclk_en));
endmodule

// File: tb/quad_ddr_serializer_tb.sv
module quad_ddr_serializer_tb;
  localparam int NCH = 4;
  localparam int W   = 12;

  logic           clk_fast = 1'b0;
  logic           arst_n;
  logic           smp_valid;
  logic [NCH*W-1:0] smp_data;
  logic           pll_lock;
  logic           pwr_down;
  logic [NCH-1:0] lane_hi, lane_lo;
  logic           bclk_en, frame_clk;

  always #2.5 clk_fast = ~clk_fast;

  quad_ddr_serializer #(.NCH(NCH), .WBITS(W)) u_dut (
    .clk_fast (clk_fast), .arst_n (arst_n), .smp_valid (smp_valid),
    .smp_data (smp_data), .pll_lock (pll_lock), .pwr_down (pwr_down),
    .lane_hi (lane_hi), .lane_lo (lane_lo), .bclk_en (bclk_en),
    .frame_clk (frame_clk)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;
  string tag = "R1";

  // behavioural reference: bit-position index into the word being sent
  int m_rel;
  int m_pos;
  bit m_run;
  bit m_frm;
  int m_word [NCH];
  int m_hold [NCH];

  always @(posedge clk_fast or negedge arst_n) begin
    if (!arst_n) begin
      m_rel = 0; m_pos = 0; m_run = 0; m_frm = 0;
      foreach (m_word[c]) begin m_word[c] = 0; m_hold[c] = 0; end
    end else begin
      if (m_rel >= 2) begin
        if (pwr_down) begin
          m_run = 0; m_pos = 0; m_frm = 0;
          foreach (m_word[c]) m_word[c] = 0;
        end else if (!pll_lock) begin
          m_run = 0;
        end else if (!m_run || m_pos == W - 2) begin
          foreach (m_word[c]) m_word[c] = m_hold[c];
          m_pos = 0; m_run = 1; m_frm = 1;
        end else begin
          m_pos = m_pos + 2;
          m_frm = (m_pos < W / 2);
        end
        if (smp_valid && !pwr_down)
          foreach (m_hold[c]) m_hold[c] = int'(smp_data[c*W +: W]);
      end
      if (m_rel < 2) m_rel++;
    end
  end

  task automatic check1(string t, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h at cycle %0d", t, what, got, exp, cycles);
    end
  endtask

  always @(negedge clk_fast) begin
    if (!done) begin
      logic [NCH-1:0] ehi, elo;
      for (int c = 0; c < NCH; c++) begin
        ehi[c] = m_word[c][W-1-m_pos];
        elo[c] = m_word[c][W-2-m_pos];
      end
      check1(tag, "lane_hi", int'(lane_hi), int'(ehi));
      check1(tag, "lane_lo", int'(lane_lo), int'(elo));
      check1((tag == "R2") ? "R4" : tag, "frame_clk", int'(frame_clk), int'(m_frm));
      check1((tag == "R2") ? "R3" : tag, "bclk_en", int'(bclk_en), int'(m_run));
    end
  end

  // watchdog
  always @(posedge clk_fast) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [W-1:0] mkw(int k, int c);
    return W'((k * 577 + c * 1301 + 91) & 12'hFFF);
  endfunction

  task automatic strobe(int k);
    @(negedge clk_fast);
    smp_valid = 1'b1;
    for (int c = 0; c < NCH; c++) smp_data[c*W +: W] = mkw(k, c);
    @(negedge clk_fast);
    smp_valid = 1'b0;
  endtask

  task automatic strobe_all(logic [W-1:0] v);
    @(negedge clk_fast);
    smp_valid = 1'b1;
    for (int c = 0; c < NCH; c++) smp_data[c*W +: W] = v;
    @(negedge clk_fast);
    smp_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_fast);
  endtask

  initial begin
    arst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    pll_lock = 1'b1; pwr_down = 1'b0;
    tag = "R1";
    idle(4);
    arst_n = 1'b1;
    idle(3);
    // R2: regular stream, one word per frame, distinct per channel (R3 alignment)
    tag = "R2";
    for (int k = 1; k <= 8; k++) begin strobe(k); idle(4); end
    idle(6);
    // R5: strobes landing at varied phases, some frames without new words
    tag = "R5";
    for (int k = 20; k < 30; k++) begin strobe(k); idle(k % 7); end
    idle(14);
    // R6: lock lost mid-frame, then restored
    tag = "R6";
    idle(2);
    pll_lock = 1'b0;
    strobe(40);
    idle(6);
    pll_lock = 1'b1;
    idle(9);
    pll_lock = 1'b0;
    idle(3);
    pll_lock = 1'b1;
    idle(8);
    // R7: power-down ignores new strobes, then resumes with the old word
    tag = "R7";
    idle(1);
    pwr_down = 1'b1;
    strobe(50);
    idle(2);
    strobe(51);
    idle(3);
    pwr_down = 1'b0;
    idle(14);
    // R8: extreme offset-binary codes pass unchanged
    tag = "R8";
    strobe_all(12'h000); idle(4);
    strobe_all(12'h7FF); idle(4);
    strobe_all(12'h800); idle(4);
    strobe_all(12'hFFF); idle(10);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule